// File: doc/BRIEF.md
# Masked Packed Vector Lane Writeback

This block is the commit stage for a unary packed operation on a 512-bit vector register made of eight 64-bit lanes. Each cycle that `issue` is high it picks an operand for every lane. That operand is either the lane's own slice of the source vector or, for a broadcast memory operand, one shared 64-bit scalar. It applies the per-lane operation to the operand and decides lane by lane what reaches the destination: the new result, the old destination lane, or zero. The active vector length sets how many lanes take part. Every bit above that length is cleared.

The per-lane operation is a stand-in for the real arithmetic unit and is chosen by a parameter. The default flips the sign bit (bit 63) of the lane. The issue is also screened for an illegal encoding. If the issue is illegal, the block raises an undefined-operation flag and leaves the destination untouched. The new destination is registered, so it appears one clock after the issue.

Top module: `masked_lane_writeback`

## Requirements
- R1: While `rst` is high at a rising clock edge, `dst` becomes all zeros and both `dst_valid` and `undef_op` become 0.
- R2: `vlen_sel` 0, 1 and 2 select 2, 4 and 8 active lanes. Lane i occupies `dst[64*i+63:64*i]` and is governed by `mask[i]`.
- R3: An active lane whose mask bit is 1, or any active lane when `mask_on` is 0, receives the lane operation of its operand. With the default parameter, that operation inverts bit 63 and leaves bits 62:0 unchanged.
- R4: When `bcst_en` and `src_is_mem` are both 1, every lane's operand is `bcst_scalar`. Otherwise lane i's operand is its own slice of `src_vec`, and `bcst_en` alone has no effect.
- R5: When `mask_on` is 1 and `zero_mode` is 0, an active lane whose mask bit is 0 takes the matching lane of `old_dst`.
- R6: When `mask_on` is 1 and `zero_mode` is 1, an active lane whose mask bit is 0 becomes zero.
- R7: Every lane at or above the active lane count is zero, whatever the mask, mode or `old_dst` value.
- R8: Mask bits of lanes beyond the active lane count have no effect on `dst`.
- R9: An issue with `rsv_field` not equal to 4'b1111, or with `vlen_sel` equal to 3, sets `undef_op` to 1 and `dst_valid` to 0 in the next cycle and leaves `dst` unchanged.
- R10: A legal issue updates `dst` and sets `dst_valid` to 1 one cycle later. In a cycle without an issue, `dst` holds and both flags return to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue | input | 1 | An operation is presented this cycle |
| src_vec | input | 512 | Packed source vector |
| bcst_scalar | input | 64 | Scalar used when broadcasting |
| bcst_en | input | 1 | Broadcast requested |
| src_is_mem | input | 1 | Source is a memory operand |
| mask | input | 8 | Per-lane write mask |
| mask_on | input | 1 | A mask is applied |
| zero_mode | input | 1 | 1: zero unselected lanes, 0: merge them |
| vlen_sel | input | 2 | Active length code (0/1/2 = 2/4/8 lanes) |
| old_dst | input | 512 | Previous destination value |
| rsv_field | input | 4 | Reserved encoding field, legal only as 4'b1111 |
| dst | output | 512 | Registered new destination |
| dst_valid | output | 1 | `dst` was updated by the last issue |
| undef_op | output | 1 | Last issue had an illegal encoding |

## Verification
The bench targets the following mistakes and the symptom each one produces:
- Broadcast keyed on `bcst_en` alone: lanes take the scalar for register operands, so their results lose their per-lane differences.
- Merge and zero modes swapped: an unselected lane shows zero where the old lane was due, or the reverse.
- Upper lanes not cleared, or mask bits beyond the active length honoured: data appears above bit 127 or 255.
- Illegal encoding committed anyway: `dst` changes when an illegal issue should leave it untouched.

// File: rtl/lane_wb_pkg.sv
package lane_wb_pkg;
    localparam int LANE_W    = 64;
    localparam int MAX_LANES = 8;
    localparam int REG_W     = LANE_W * MAX_LANES;
    localparam int CNT_W     = $clog2(MAX_LANES + 1);

    typedef enum logic [1:0] {
        VL_2LANE = 2'd0,
        VL_4LANE = 2'd1,
        VL_8LANE = 2'd2,
        VL_BAD   = 2'd3
    } vlen_e;

    typedef enum logic [1:0] {
        OP_SIGN_FLIP,
        OP_BIT_INVERT,
        OP_TWOS_NEG
    } lane_op_e;

    typedef enum logic [1:0] {
        PICK_ZERO,
        PICK_OLD,
        PICK_NEW
    } lane_pick_e;

    typedef struct packed {
        logic       active;
        lane_pick_e pick;
    } lane_ctl_t;

    function automatic logic [CNT_W-1:0] lane_count(input vlen_e v);
        case (v)
            VL_2LANE: lane_count = CNT_W'(2);
            VL_4LANE: lane_count = CNT_W'(4);
            VL_8LANE: lane_count = CNT_W'(8);
            default:  lane_count = '0;
        endcase
    endfunction

    function automatic logic [LANE_W-1:0] lane_apply(input lane_op_e k,
                                                     input logic [LANE_W-1:0] x);
        case (k)
            OP_BIT_INVERT: lane_apply = ~x;
            OP_TWOS_NEG:   lane_apply = -x;
            default:       lane_apply = {~x[LANE_W-1], x[LANE_W-2:0]};
        endcase
    endfunction
endpackage

// File: rtl/wb_lane_ctl.sv
module wb_lane_ctl
    import lane_wb_pkg::*;
#(
    parameter int LANES = MAX_LANES
) (
    input  logic [LANES-1:0] mask,
    input  logic             mask_on,
    input  logic             zero_mode,
    input  vlen_e            vlen,
    output lane_ctl_t        ctl [LANES]
);
    localparam int CW = $clog2(LANES + 1);
    logic [CNT_W-1:0] n_act;

    assign n_act = lane_count(vlen);

    for (genvar i = 0; i < LANES; i++) begin : g_ctl
        always_comb begin
            ctl[i].active = (CNT_W'(i) < n_act);
            if (!ctl[i].active)
                ctl[i].pick = PICK_ZERO;
            else if (!mask_on || mask[i])
                ctl[i].pick = PICK_NEW;
            else if (zero_mode)
                ctl[i].pick = PICK_ZERO;
            else
                ctl[i].pick = PICK_OLD;
        end
    end

    // R7: a lane outside the active length never takes new or old data
    always_comb begin
        for (int i = 0; i < LANES; i++)
            if (!ctl[i].active)
                assert_idle_lane_zero_R7: assert (ctl[i].pick == PICK_ZERO);
    end

    logic [CW-1:0] unused_cw;
    assign unused_cw = '0;
endmodule

// File: rtl/wb_lane_src.sv
module wb_lane_src
    import lane_wb_pkg::*;
#(
    parameter int LANES = MAX_LANES,
    parameter int W     = LANE_W
) (
    input  logic [LANES*W-1:0] src_vec,
    input  logic [W-1:0]       bcst_scalar,
    input  logic               bcst_en,
    input  logic               src_is_mem,
    output logic [W-1:0]       opnd [LANES]
);
    logic use_bcst;
    assign use_bcst = bcst_en && src_is_mem;

    for (genvar i = 0; i < LANES; i++) begin : g_src
        assign opnd[i] = use_bcst ? bcst_scalar : src_vec[i*W +: W];
    end
endmodule

// File: rtl/wb_lane_commit.sv
module wb_lane_commit
    import lane_wb_pkg::*;
#(
    parameter int       LANES = MAX_LANES,
    parameter int       W     = LANE_W,
    parameter lane_op_e OP    = OP_SIGN_FLIP
) (
    input  logic [W-1:0]       opnd    [LANES],
    input  lane_ctl_t          ctl     [LANES],
    input  logic [LANES*W-1:0] old_dst,
    output logic [LANES*W-1:0] new_dst
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [W-1:0] result;
        assign result = lane_apply(OP, opnd[i]);
        always_comb begin
            case (ctl[i].pick)
                PICK_NEW: new_dst[i*W +: W] = result;
                PICK_OLD: new_dst[i*W +: W] = old_dst[i*W +: W];
                default:  new_dst[i*W +: W] = '0;
            endcase
        end
    end
endmodule

// File: rtl/masked_lane_writeback.sv
module masked_lane_writeback
    import lane_wb_pkg::*;
#(
    parameter lane_op_e OP = OP_SIGN_FLIP
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 issue,
    input  logic [REG_W-1:0]     src_vec,
    input  logic [LANE_W-1:0]    bcst_scalar,
    input  logic                 bcst_en,
    input  logic                 src_is_mem,
    input  logic [MAX_LANES-1:0] mask,
    input  logic                 mask_on,
    input  logic                 zero_mode,
    input  logic [1:0]           vlen_sel,
    input  logic [REG_W-1:0]     old_dst,
    input  logic [3:0]           rsv_field,
    output logic [REG_W-1:0]     dst,
    output logic                 dst_valid,
    output logic                 undef_op
);
    localparam logic [3:0] RSV_OK = 4'b1111;

    vlen_e              vlen;
    lane_ctl_t          ctl  [MAX_LANES];
    logic [LANE_W-1:0]  opnd [MAX_LANES];
    logic [REG_W-1:0]   new_dst;
    logic               legal;

    assign vlen  = vlen_e'(vlen_sel);
    assign legal = (rsv_field == RSV_OK) && (vlen != VL_BAD);

    wb_lane_ctl #(.LANES(MAX_LANES)) u_ctl (
        .mask(mask), .mask_on(mask_on), .zero_mode(zero_mode),
        .vlen(vlen), .ctl(ctl)
    );

    wb_lane_src #(.LANES(MAX_LANES), .W(LANE_W)) u_src (
        .src_vec(src_vec), .bcst_scalar(bcst_scalar), .bcst_en(bcst_en),
        .src_is_mem(src_is_mem), .opnd(opnd)
    );

    wb_lane_commit #(.LANES(MAX_LANES), .W(LANE_W), .OP(OP)) u_commit (
        .opnd(opnd), .ctl(ctl), .old_dst(old_dst), .new_dst(new_dst)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dst       <= '0;
            dst_valid <= 1'b0;
            undef_op  <= 1'b0;
        end else begin
            dst_valid <= issue && legal;
            undef_op  <= issue && !legal;
            if (issue && legal)
                dst <= new_dst;
        end
    end

    assert_flags_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
        !(dst_valid && undef_op));

    assert_illegal_holds_R9: assert property (@(posedge clk) disable iff (rst)
        issue && !legal |=> undef_op && !dst_valid && $stable(dst));

    assert_idle_holds_R10: assert property (@(posedge clk) disable iff (rst)
        !issue |=> !dst_valid && !undef_op && $stable(dst));

    assert_upper_cleared_R7: assert property (@(posedge clk) disable iff (rst)
        issue && legal && vlen == VL_2LANE |=> dst[REG_W-1:2*LANE_W] == '0);

    assert_merge_lane0_R5: assert property (@(posedge clk) disable iff (rst)
        issue && legal && mask_on && !zero_mode && !mask[0]
        |=> dst[LANE_W-1:0] == $past(old_dst[LANE_W-1:0]));

    assert_zero_lane0_R6: assert property (@(posedge clk) disable iff (rst)
        issue && legal && mask_on && zero_mode && !mask[0]
        |=> dst[LANE_W-1:0] == '0);

    assert_bcst_same_R4: assert property (@(posedge clk) disable iff (rst)
        issue && legal && bcst_en && src_is_mem && !mask_on && vlen == VL_8LANE
        |=> dst[LANE_W-1:0] == dst[REG_W-1:REG_W-LANE_W]);
endmodule

// File: tb/tb_masked_lane_writeback.sv
module tb_masked_lane_writeback;
    localparam int CLK_PERIOD = 10;
    localparam int NL = 8;
    localparam int LW = 64;

    typedef struct packed {
        logic [7:0] msk;
        logic       mon;
        logic       zm;
        logic [1:0] vl;
        logic       be;
        logic       mem;
    } vec_t;

    localparam int NVEC = 12;
    localparam vec_t VECS [NVEC] = '{
        '{8'hFF, 1'b0, 1'b0, 2'd2, 1'b0, 1'b0},
        '{8'h00, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0},
        '{8'hA5, 1'b1, 1'b0, 2'd2, 1'b0, 1'b0},
        '{8'hA5, 1'b1, 1'b1, 2'd2, 1'b0, 1'b0},
        '{8'h0E, 1'b1, 1'b0, 2'd1, 1'b0, 1'b0},
        '{8'hFD, 1'b1, 1'b1, 2'd0, 1'b0, 1'b0},
        '{8'hFC, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0},
        '{8'h00, 1'b0, 1'b0, 2'd2, 1'b1, 1'b1},
        '{8'h33, 1'b1, 1'b0, 2'd1, 1'b1, 1'b1},
        '{8'hFF, 1'b0, 1'b0, 2'd2, 1'b1, 1'b0},
        '{8'h5A, 1'b1, 1'b1, 2'd2, 1'b0, 1'b1},
        '{8'h01, 1'b1, 1'b0, 2'd1, 1'b1, 1'b1}
    };

    logic           clk = 1'b0;
    logic           rst;
    logic           issue;
    logic [511:0]   src_vec;
    logic [63:0]    bcst_scalar;
    logic           bcst_en, src_is_mem, mask_on, zero_mode;
    logic [7:0]     mask;
    logic [1:0]     vlen_sel;
    logic [511:0]   old_dst;
    logic [3:0]     rsv_field;
    logic [511:0]   dst;
    logic           dst_valid, undef_op;

    int total = 0;
    int bad   = 0;
    logic [511:0] last_dst;

    always #(CLK_PERIOD/2) clk = ~clk;

    masked_lane_writeback dut (
        .clk(clk), .rst(rst), .issue(issue), .src_vec(src_vec),
        .bcst_scalar(bcst_scalar), .bcst_en(bcst_en), .src_is_mem(src_is_mem),
        .mask(mask), .mask_on(mask_on), .zero_mode(zero_mode),
        .vlen_sel(vlen_sel), .old_dst(old_dst), .rsv_field(rsv_field),
        .dst(dst), .dst_valid(dst_valid), .undef_op(undef_op)
    );

    function automatic logic [63:0] sflip(input logic [63:0] x);
        sflip = x ^ 64'h8000_0000_0000_0000;
    endfunction

    task automatic chk(input string req, input logic [511:0] act, input logic [511:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic fill_data(input int seed);
        for (int i = 0; i < NL; i++) begin
            src_vec[i*LW +: LW] = {32'h1230_0000 + 32'(seed * 16 + i), 32'hC0DE_0000 ^ 32'(i * 7919)};
            old_dst[i*LW +: LW] = {32'h0DD0_0000 + 32'(i), 32'(seed) ^ 32'hFACE_0000};
        end
        bcst_scalar = {32'h4BC5_0000 + 32'(seed), 32'h0000_0F0F};
    endtask

    // one issue: drive at negedge, result visible at next negedge
    task automatic run_vec(input vec_t v, input int seed);
        logic [511:0] exp;
        int n;
        fill_data(seed);
        mask = v.msk; mask_on = v.mon; zero_mode = v.zm; vlen_sel = v.vl;
        bcst_en = v.be; src_is_mem = v.mem; rsv_field = 4'b1111; issue = 1'b1;
        n = 2 << v.vl; // R2: 0/1/2 -> 2/4/8 lanes
        @(negedge clk);
        issue = 1'b0;
        for (int i = 0; i < NL; i++) begin
            logic [63:0] opv, e;
            opv = (v.be && v.mem) ? bcst_scalar : src_vec[i*LW +: LW];
            if (i >= n) e = '0;
            else if (!v.mon || v.msk[i]) e = sflip(opv);
            else if (v.zm) e = '0;
            else e = old_dst[i*LW +: LW];
            exp[i*LW +: LW] = e;
        end
        for (int i = 0; i < NL; i++) begin
            string tag;
            if (i >= n) tag = v.msk[i] ? "R8" : "R7";
            else if (!v.mon || v.msk[i]) tag = (v.be && v.mem) ? "R4" : (v.be ? "R4" : "R3");
            else tag = v.zm ? "R6" : "R5";
            chk($sformatf("%s vec%0d lane%0d", tag, seed, i),
                {448'b0, dst[i*LW +: LW]}, {448'b0, exp[i*LW +: LW]});
        end
        chk("R10 dst_valid after issue", {511'b0, dst_valid}, 512'd1);
        last_dst = exp;
    endtask

    initial begin
        rst = 1'b1; issue = 1'b0; src_vec = '1; bcst_scalar = '1; bcst_en = 1'b1;
        src_is_mem = 1'b1; mask = '1; mask_on = 1'b0; zero_mode = 1'b0;
        vlen_sel = 2'd2; old_dst = '1; rsv_field = 4'b1111;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 dst reset", dst, '0);
        chk("R1 flags reset", {510'b0, dst_valid, undef_op}, '0);
        rst = 1'b0;
        @(negedge clk);

        for (int k = 0; k < NVEC; k++) run_vec(VECS[k], k);

        for (int k = 0; k < 40; k++) begin
            vec_t r;
            r.msk = 8'($urandom); r.mon = 1'($urandom); r.zm = 1'($urandom);
            r.vl = 2'($urandom_range(0, 2)); r.be = 1'($urandom); r.mem = 1'($urandom);
            run_vec(r, 100 + k);
        end

        // R10: idle cycle holds dst, clears flags
        @(negedge clk);
        chk("R10 dst holds when idle", dst, last_dst);
        chk("R10 flags low when idle", {510'b0, dst_valid, undef_op}, '0);

        // R9: bad reserved field
        fill_data(7); mask_on = 1'b0; vlen_sel = 2'd2; rsv_field = 4'b1110; issue = 1'b1;
        @(negedge clk);
        issue = 1'b0;
        chk("R9 undef on bad field", {510'b0, undef_op, dst_valid}, 512'd2);
        chk("R9 dst unchanged on bad field", dst, last_dst);

        // R9: bad length code
        rsv_field = 4'b1111; vlen_sel = 2'd3; issue = 1'b1;
        @(negedge clk);
        issue = 1'b0; vlen_sel = 2'd2;
        chk("R9 undef on bad length", {510'b0, undef_op, dst_valid}, 512'd2);
        chk("R9 dst unchanged on bad length", dst, last_dst);

        @(negedge clk);
        chk("R10 undef clears", {511'b0, undef_op}, '0);

        // R1: reset mid-run clears
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 dst cleared by reset", dst, '0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule